// File: doc/BRIEF.md
# Coded-Ratio Reference Divider with Auxiliary Output Select

This block sits behind a reference clock in a frequency synthesiser and divides it down to the comparison rate that feeds the phase detector. The ratio is not a binary count. It comes from a 5-bit code, and the code picks a base factor (2, 5, 6 or 7) and a power-of-two scale. This gives 29 legal ratios between 2 and 448. The three codes that have no ratio are flagged and ignored. Each divided period produces a one-cycle comparison strobe.

A second path drives an auxiliary reference pin so that a second synthesiser can take its reference from this one. Under two registered control bits, that pin carries the undivided reference, a near-square version of the divided signal, or nothing (output enable low). Both control bits come out of reset at 1, so the divided signal is on the pin by default. A new ratio is only adopted at a terminal count, so no comparison period is ever cut short or stretched by a reprogram.

Top module: `refdiv_top`

## Requirements
- R1: With code bits [4:3] = 00, the division ratio is 2 shifted left by code bits [2:0], which gives 2, 4, 8 and so on up to 256.
- R2: With code bits [4:3] = 01, 10 or 11 and bits [2:0] = k in 1..7, the ratio is 5, 6 or 7 respectively, times 2^(k-1). This gives up to 320, 384 and 448.
- R3: The codes 01000, 10000 and 11000 are illegal. While one of them is applied, `code_illegal_o` is high in the same cycle, and the ratio in use stays the last legal one. Every legal code drives `code_illegal_o` low.
- R4: `fcomp_o` is a single-cycle high pulse repeating every N clock cycles, where N is the active ratio.
- R5: A code change is sampled only on the clock edge that raises `fcomp_o`. The period in progress completes at its old length, and the next period uses the new ratio.
- R6: The divided square wave rises on the same edge as `fcomp_o`. It is high for floor(N/2) cycles and low for the remaining cycles of each period.
- R7: One clock after `out_en_i` is sampled low, `aux_oe_o` is 0 and `aux_data_o` is 0, whatever `out_sel_i` is.
- R8: One clock after `out_en_i` = 1 and `out_sel_i` = 0 are sampled, `aux_oe_o` is 1 and `aux_data_o` follows `clk_i` (the undivided reference).
- R9: One clock after `out_en_i` = 1 and `out_sel_i` = 1 are sampled, `aux_oe_o` is 1 and `aux_data_o` carries the divided square wave of R6.
- R10: Synchronous reset (`rst_i` high) has the following effects:
  - it forces the enable and select state to 1, so `aux_oe_o` = 1 during reset whatever the inputs are;
  - it clears the count and holds `fcomp_o` low;
  - it loads the ratio from the applied code, or 2 if that code is illegal.
  The first strobe comes N cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; also the undivided auxiliary source |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_code_i | input | 5 | Ratio code: [4:3] base group, [2:0] scale |
| out_en_i | input | 1 | Auxiliary output enable request |
| out_sel_i | input | 1 | Auxiliary source: 0 reference, 1 divided |
| fcomp_o | output | 1 | One-cycle comparison strobe |
| aux_data_o | output | 1 | Auxiliary output data |
| aux_oe_o | output | 1 | Auxiliary output enable (0 means high impedance) |
| code_illegal_o | output | 1 | High while the applied code has no ratio |

## Verification
The bench measures strobe spacing for codes from every base group, including both ends of each group. It also applies all three illegal codes. A decoder with an off-by-one scale, or one that loads zero on an illegal code, shows up as a wrong period or a hung strobe. A mid-period reprogram checks that the running period is not truncated, which a design that reloads the ratio immediately would do. The duty count on ratios 2, 5 and 448 catches a misplaced half-period toggle. The reset test with both control inputs low catches select registers that reset to 0 instead of 1.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int GRP_W     = 2;
    localparam int EXP_W     = 3;
    localparam int CODE_W    = GRP_W + EXP_W;
    localparam int CNT_W     = 9;
    localparam int DEF_RATIO = 2;

    typedef enum logic [GRP_W-1:0] {
        GRP_BIN = 2'd0,
        GRP_X5  = 2'd1,
        GRP_X6  = 2'd2,
        GRP_X7  = 2'd3
    } grp_e;

    typedef struct packed {
        grp_e             grp;
        logic [EXP_W-1:0] scale;
    } code_t;

    typedef struct packed {
        logic             legal;
        logic [CNT_W-1:0] ratio;
    } ratio_t;

    typedef enum logic [1:0] {
        AUX_OFF = 2'd0,
        AUX_REF = 2'd1,
        AUX_CMP = 2'd2
    } aux_mode_e;

    function automatic logic [CNT_W-1:0] base_of(grp_e g);
        logic [CNT_W-1:0] b;
        case (g)
            GRP_BIN: b = CNT_W'(2);
            GRP_X5:  b = CNT_W'(5);
            GRP_X6:  b = CNT_W'(6);
            default: b = CNT_W'(7);
        endcase
        return b;
    endfunction

    function automatic ratio_t decode_code(code_t c);
        ratio_t r;
        if (c.grp == GRP_BIN) begin
            r.legal = 1'b1;
            r.ratio = base_of(c.grp) << c.scale;
        end else if (c.scale == '0) begin
            r.legal = 1'b0;
            r.ratio = '0;
        end else begin
            r.legal = 1'b1;
            r.ratio = base_of(c.grp) << (c.scale - EXP_W'(1));
        end
        return r;
    endfunction

endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
    import refdiv_pkg::*;
(
    input  code_t  code_i,
    output ratio_t ratio_o
);

    always_comb begin
        ratio_o = decode_code(code_i);
    end

    // R1 R2
    always_comb begin
        if (ratio_o.legal) begin
            legal_range_chk: assert (ratio_o.ratio >= CNT_W'(2) && ratio_o.ratio <= CNT_W'(448))
                else $error("decoded ratio out of range");
        end
    end

endmodule

// File: rtl/refdiv_core.sv
module refdiv_core
    import refdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  ratio_t next_i,
    output logic   strobe_o,
    output logic   square_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ratio_q;
    logic [CNT_W-1:0] half_m1;
    logic             term;

    assign term    = (cnt_q == ratio_q - CNT_W'(1));
    assign half_m1 = (ratio_q >> 1) - CNT_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q    <= '0;
            ratio_q  <= next_i.legal ? next_i.ratio : CNT_W'(DEF_RATIO);
            strobe_o <= 1'b0;
            square_o <= 1'b0;
        end else if (term) begin
            cnt_q    <= '0;
            strobe_o <= 1'b1;
            square_o <= 1'b1;
            if (next_i.legal) begin
                ratio_q <= next_i.ratio;
            end
        end else begin
            cnt_q    <= cnt_q + CNT_W'(1);
            strobe_o <= 1'b0;
            if (cnt_q == half_m1) begin
                square_o <= 1'b0;
            end
        end
    end

    // R4
    strobe_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o);

    // R4
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < ratio_q);

    // R5
    ratio_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !term |=> $stable(ratio_q));

    // R3
    illegal_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (term && !next_i.legal) |=> $stable(ratio_q));

    // R6
    square_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(square_o) |-> strobe_o);

endmodule

// File: rtl/refdiv_outsel.sv
module refdiv_outsel
    import refdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic sel_i,
    input  logic ref_i,
    input  logic div_i,
    output logic data_o,
    output logic oe_o
);

    aux_mode_e mode_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= AUX_CMP;
        end else if (!en_i) begin
            mode_q <= AUX_OFF;
        end else if (sel_i) begin
            mode_q <= AUX_CMP;
        end else begin
            mode_q <= AUX_REF;
        end
    end

    always_comb begin
        case (mode_q)
            AUX_REF: begin
                oe_o   = 1'b1;
                data_o = ref_i;
            end
            AUX_CMP: begin
                oe_o   = 1'b1;
                data_o = div_i;
            end
            default: begin
                oe_o   = 1'b0;
                data_o = 1'b0;
            end
        endcase
    end

    // R7
    oe_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (oe_o == $past(en_i)));

    // R7
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !oe_o |-> !data_o);

    // R9
    div_route_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(en_i) && $past(sel_i)) |-> (data_o == div_i));

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [CODE_W-1:0]     ratio_code_i,
    input  logic                  out_en_i,
    input  logic                  out_sel_i,
    output logic                  fcomp_o,
    output logic                  aux_data_o,
    output logic                  aux_oe_o,
    output logic                  code_illegal_o
);

    code_t  code_w;
    ratio_t dec_w;
    logic   square_w;

    assign code_w         = code_t'(ratio_code_i);
    assign code_illegal_o = !dec_w.legal;

    refdiv_decode u_decode (
        .code_i  (code_w),
        .ratio_o (dec_w)
    );

    refdiv_core u_core (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .next_i   (dec_w),
        .strobe_o (fcomp_o),
        .square_o (square_w)
    );

    refdiv_outsel u_outsel (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (out_en_i),
        .sel_i  (out_sel_i),
        .ref_i  (clk_i),
        .div_i  (square_w),
        .data_o (aux_data_o),
        .oe_o   (aux_oe_o)
    );

    // R3
    illegal_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ratio_code_i[2:0] == 3'b000 && ratio_code_i[4:3] != 2'b00) |-> code_illegal_o);

    // R10
    reset_quiet_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!fcomp_o && aux_oe_o));

endmodule

// File: tb/tb_refdiv_top.sv
module tb_refdiv_top;

    logic       clk_i = 1'b0;
    logic       rst_i;
    logic [4:0] ratio_code_i;
    logic       out_en_i;
    logic       out_sel_i;
    logic       fcomp_o;
    logic       aux_data_o;
    logic       aux_oe_o;
    logic       code_illegal_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk_i = ~clk_i;

    refdiv_top dut (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .ratio_code_i   (ratio_code_i),
        .out_en_i       (out_en_i),
        .out_sel_i      (out_sel_i),
        .fcomp_o        (fcomp_o),
        .aux_data_o     (aux_data_o),
        .aux_oe_o       (aux_oe_o),
        .code_illegal_o (code_illegal_o)
    );

    // {code, expected ratio, expected illegal}
    localparam int NV = 14;
    localparam logic [14:0] VEC [NV] = '{
        {5'b00000, 9'd2,   1'b0},
        {5'b00011, 9'd16,  1'b0},
        {5'b00111, 9'd256, 1'b0},
        {5'b01001, 9'd5,   1'b0},
        {5'b01010, 9'd10,  1'b0},
        {5'b01111, 9'd320, 1'b0},
        {5'b10001, 9'd6,   1'b0},
        {5'b10100, 9'd48,  1'b0},
        {5'b11111, 9'd448, 1'b0},
        {5'b11001, 9'd7,   1'b0},
        {5'b01000, 9'd0,   1'b1},
        {5'b10000, 9'd0,   1'b1},
        {5'b11000, 9'd0,   1'b1},
        {5'b00001, 9'd4,   1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        do @(negedge clk_i); while (!fcomp_o);
    endtask

    task automatic measure(output int cyc, output int high);
        cyc  = 0;
        high = 0;
        if (aux_data_o) high++;
        do begin
            @(negedge clk_i);
            cyc++;
            if (!fcomp_o && aux_data_o) high++;
        end while (!fcomp_o);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc;
        int high;
        int prev;
        rst_i        = 1'b1;
        ratio_code_i = 5'b00010;
        out_en_i     = 1'b0;
        out_sel_i    = 1'b0;
        repeat (4) @(negedge clk_i);

        // R10 reset state with both control inputs low
        chk("R10 oe in reset", int'(aux_oe_o), 1);
        chk("R10 fcomp in reset", int'(fcomp_o), 0);
        chk("R10 data in reset", int'(aux_data_o), 0);

        rst_i = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk_i);
            cyc++;
        end while (!fcomp_o && cyc < 100);
        chk("R10 first strobe delay", cyc, 8);
        chk("R7 oe after release with en low", int'(aux_oe_o), 0);

        out_en_i  = 1'b1;
        out_sel_i = 1'b1;
        prev = 8;

        // R1 R2 R3 R4 vector walk
        for (int i = 0; i < NV; i++) begin
            ratio_code_i = VEC[i][14:10];
            #1;
            chk(VEC[i][0] ? "R3 illegal flag" : "R1/R2 legal flag",
                int'(code_illegal_o), int'(VEC[i][0]));
            wait_strobe();
            measure(cyc, high);
            if (VEC[i][0]) begin
                chk("R3 ratio held", cyc, prev);
            end else begin
                chk(VEC[i][14:13] == 2'b00 ? "R1 period" : "R2 period",
                    cyc, int'(VEC[i][9:1]));
                prev = int'(VEC[i][9:1]);
            end
        end

        // R5 mid-period change keeps running period
        ratio_code_i = 5'b00010;
        wait_strobe();
        wait_strobe();
        repeat (3) @(negedge clk_i);
        ratio_code_i = 5'b00000;
        cyc = 3;
        do begin
            @(negedge clk_i);
            cyc++;
        end while (!fcomp_o);
        chk("R5 running period kept", cyc, 8);
        measure(cyc, high);
        chk("R5 new ratio next period", cyc, 2);

        // R6 R9 duty on divided path
        chk("R9 oe on divided path", int'(aux_oe_o), 1);
        ratio_code_i = 5'b00000;
        wait_strobe();
        wait_strobe();
        chk("R6 high on strobe", int'(aux_data_o), 1);
        measure(cyc, high);
        chk("R6 duty ratio 2", high, 1);
        ratio_code_i = 5'b01001;
        wait_strobe();
        measure(cyc, high);
        chk("R9 period ratio 5", cyc, 5);
        chk("R6 duty ratio 5", high, 2);
        ratio_code_i = 5'b11111;
        wait_strobe();
        measure(cyc, high);
        chk("R6 duty ratio 448", high, 224);

        // R7 disabled output
        ratio_code_i = 5'b00000;
        out_en_i = 1'b0;
        out_sel_i = 1'b1;
        repeat (2) @(negedge clk_i);
        high = 0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk_i);
            #2;
            if (aux_data_o || aux_oe_o) high++;
            @(negedge clk_i);
            if (aux_data_o || aux_oe_o) high++;
        end
        chk("R7 off output quiet", high, 0);

        // R8 reference path
        out_en_i  = 1'b1;
        out_sel_i = 1'b0;
        repeat (2) @(negedge clk_i);
        chk("R8 oe", int'(aux_oe_o), 1);
        high = 0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk_i);
            #2;
            if (aux_data_o !== 1'b1) high++;
            @(negedge clk_i);
            #1;
            if (aux_data_o !== 1'b0) high++;
        end
        chk("R8 follows reference", high, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule